// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits between an interrupt source controller and one processor. It keeps a single pending slot (source id plus priority) and a current priority threshold, and drives one interrupt line to the processor. Priorities are 8-bit values where a smaller number is more favoured. Incoming presentation requests either win the slot or go back to the source as a reject. A request that wins can push out a less favoured pending id, which is also rejected back to the source.

The processor side uses four register operations. It can write the threshold, write the priority of a local inter-processor request, accept the pending interrupt (read and acknowledge), and write end-of-interrupt. The inter-processor request uses a reserved source id and competes for the slot like any other interrupt. Toward the source controller the block sends reject, resend and end-of-interrupt notices, each as a one-cycle pulse. Only one operation or request is handled per clock. Register operations go first, and a request that arrives at the same time is held off with a ready signal.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the threshold is 0x00, the slot is empty (id 0), `irq_out` is low, every notice output is low and the inter-processor priority is 0xff.
- R2: An accept (`op_code` 2) returns the status word on `acc_word` with `acc_valid` high one cycle later. The threshold is in bits 31:24 and the pending id in bits 23:0, where id 0 means nothing is pending. Afterwards `irq_out` is low, the slot is empty and the threshold equals the accepted priority.
- R3: An incoming request is rejected when its priority is greater than or equal to the threshold, or when an id is pending whose priority is less than or equal to the request's. A rejected request raises `rej_valid` with `rej_id` equal to the request id, and leaves the slot unchanged.
- R4: A request that wins is latched into the slot and `irq_out` is raised. If an id was pending before, that id is rejected at the same time.
- R5: Writing the inter-processor priority (`op_code` 1, value in bits 7:0) below the threshold loads source id 2 with that priority and raises `irq_out`. A pending id that this displaces is rejected.
- R6: An inter-processor write has no effect on the slot in two cases: the value is greater than or equal to the threshold, or the pending priority is less than or equal to the value.
- R7: A threshold write (`op_code` 0, value in bits 7:0) below the old threshold clears the slot when the pending priority is greater than or equal to the new threshold. It also lowers `irq_out` and rejects that id. A more favoured pending id is kept.
- R8: A threshold write that is equal to or above the old threshold, made with the slot empty, pulses `resend_req`. It first loads id 2 if the inter-processor priority is below the new threshold.
- R9: An end-of-interrupt write (`op_code` 3) pulses `eoi_valid` with `eoi_id` equal to bits 23:0 and loads the threshold from bits 31:24. It pulses `resend_req` (with the inter-processor check of R8) only if the slot is empty.
- R10: While `op_valid` is high, `req_ready` is low and no request is taken. The request is taken on the first cycle with `op_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 2 | 0 threshold, 1 inter-processor priority, 2 accept, 3 end-of-interrupt |
| op_data | input | 32 | Operation write data |
| req_valid | input | 1 | Presentation request from source controller |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_id | input | 24 | Requesting source id |
| req_prio | input | 8 | Requesting priority |
| irq_out | output | 1 | Interrupt line to processor |
| rej_valid | output | 1 | Reject notice pulse |
| rej_id | output | 24 | Rejected source id |
| resend_req | output | 1 | Resend notice pulse |
| eoi_valid | output | 1 | End-of-interrupt notice pulse |
| eoi_id | output | 24 | Source id being retired |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | Status word returned by accept |

## Verification
Incoming requests are tried at priorities equal to the threshold, above it, equal to the pending priority and more favoured than the pending one. These cases separate the two reject conditions from the displacement path. Inter-processor writes are tried above the threshold, behind a more favoured pending id and in front of a less favoured one. Threshold and end-of-interrupt writes are tried with the slot empty and full, which shows when a resend and an inter-processor reload are issued. An operation that collides with a request shows that the request is held off and is not lost.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    typedef enum logic [1:0] {
        OP_SET_THR = 2'd0,
        OP_SET_IPI = 2'd1,
        OP_ACCEPT  = 2'd2,
        OP_EOI     = 2'd3
    } ipc_op_e;

    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_THR  = 3'd1,
        CMD_IPI  = 3'd2,
        CMD_ACC  = 3'd3,
        CMD_EOI  = 3'd4,
        CMD_REQ  = 3'd5
    } ipc_cmd_e;
endpackage

// File: rtl/ipc_arb.sv
module ipc_arb
    import ipc_pkg::*;
#(
    parameter int ID_W   = 24,
    parameter int PRIO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [1:0]               op_code,
    input  logic [PRIO_W+ID_W-1:0]   op_data,
    input  logic                     req_valid,
    input  logic [ID_W-1:0]          req_id,
    input  logic [PRIO_W-1:0]        req_prio,
    output logic                     req_ready,
    output ipc_cmd_e                 cmd_kind,
    output logic [PRIO_W+ID_W-1:0]   cmd_word,
    output logic [ID_W-1:0]          cmd_id,
    output logic [PRIO_W-1:0]        cmd_prio
);
    always_comb begin
        cmd_kind = CMD_IDLE;
        if (op_valid) begin
            case (ipc_op_e'(op_code))
                OP_SET_THR: cmd_kind = CMD_THR;
                OP_SET_IPI: cmd_kind = CMD_IPI;
                OP_ACCEPT:  cmd_kind = CMD_ACC;
                OP_EOI:     cmd_kind = CMD_EOI;
                default:    cmd_kind = CMD_IDLE;
            endcase
        end else if (req_valid) begin
            cmd_kind = CMD_REQ;
        end
    end

    assign req_ready = !op_valid;
    assign cmd_word  = op_data;
    assign cmd_id    = req_id;
    assign cmd_prio  = req_prio;

    // R10: a register operation always holds off the request side
    p_op_holds_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (!req_ready && cmd_kind != CMD_REQ));
endmodule

// File: rtl/ipc_judge.sv
module ipc_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] gate_thr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              take,
    output logic              bump
);
    logic blocked_thr;
    logic blocked_pend;

    assign blocked_thr  = cand_prio >= gate_thr;
    assign blocked_pend = busy && (pend_prio <= cand_prio);
    assign take         = !blocked_thr && !blocked_pend;
    assign bump         = take && busy;
endmodule

// File: rtl/ipc_core.sv
module ipc_core
    import ipc_pkg::*;
#(
    parameter int ID_W   = 24,
    parameter int PRIO_W = 8,
    parameter int IPI_ID = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  ipc_cmd_e                 cmd_kind,
    input  logic [PRIO_W+ID_W-1:0]   cmd_word,
    input  logic [ID_W-1:0]          cmd_id,
    input  logic [PRIO_W-1:0]        cmd_prio,
    output logic                     irq,
    output logic                     rej_valid,
    output logic [ID_W-1:0]          rej_id,
    output logic                     resend,
    output logic                     eoi_valid,
    output logic [ID_W-1:0]          eoi_id,
    output logic                     rd_valid,
    output logic [PRIO_W+ID_W-1:0]   rd_data
);
    localparam int STATUS_W = PRIO_W + ID_W;
    localparam logic [ID_W-1:0]   IPI_CODE  = ID_W'(IPI_ID);
    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

    typedef struct packed {
        logic [PRIO_W-1:0]   thr;
        logic [ID_W-1:0]     pend_id;
        logic [PRIO_W-1:0]   pend_prio;
        logic [PRIO_W-1:0]   ipi;
        logic                irq;
        logic                rej_v;
        logic [ID_W-1:0]     rej_id;
        logic                resend;
        logic                eoi_v;
        logic [ID_W-1:0]     eoi_id;
        logic                rd_v;
        logic [STATUS_W-1:0] rd_data;
    } st_t;

    st_t st_d, st_q;

    logic              busy;
    logic [PRIO_W-1:0] new_thr;
    logic [PRIO_W-1:0] ipi_cand;
    logic [PRIO_W-1:0] ipi_gate;
    logic              req_take, req_bump;
    logic              ipi_take, ipi_bump;

    assign busy     = |st_q.pend_id;
    assign new_thr  = (cmd_kind == CMD_THR) ? cmd_word[PRIO_W-1:0]
                                            : cmd_word[STATUS_W-1 -: PRIO_W];
    assign ipi_cand = (cmd_kind == CMD_IPI) ? cmd_word[PRIO_W-1:0] : st_q.ipi;
    assign ipi_gate = (cmd_kind == CMD_IPI) ? st_q.thr : new_thr;

    ipc_judge #(.PRIO_W(PRIO_W)) u_req_judge (
        .gate_thr  (st_q.thr),
        .busy      (busy),
        .pend_prio (st_q.pend_prio),
        .cand_prio (cmd_prio),
        .take      (req_take),
        .bump      (req_bump)
    );

    ipc_judge #(.PRIO_W(PRIO_W)) u_ipi_judge (
        .gate_thr  (ipi_gate),
        .busy      (busy),
        .pend_prio (st_q.pend_prio),
        .cand_prio (ipi_cand),
        .take      (ipi_take),
        .bump      (ipi_bump)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rej_v  = 1'b0;
        st_d.resend = 1'b0;
        st_d.eoi_v  = 1'b0;
        st_d.rd_v   = 1'b0;
        case (cmd_kind)
            CMD_REQ: begin
                st_d.rej_v = 1'b1;
                if (req_take) begin
                    st_d.rej_id    = st_q.pend_id;
                    st_d.rej_v     = req_bump;
                    st_d.pend_id   = cmd_id;
                    st_d.pend_prio = cmd_prio;
                    st_d.irq       = 1'b1;
                end else begin
                    st_d.rej_id = cmd_id;
                end
            end
            CMD_IPI: begin
                st_d.ipi = ipi_cand;
                if (ipi_take) begin
                    st_d.rej_v     = ipi_bump;
                    st_d.rej_id    = st_q.pend_id;
                    st_d.pend_id   = IPI_CODE;
                    st_d.pend_prio = ipi_cand;
                    st_d.irq       = 1'b1;
                end
            end
            CMD_THR: begin
                st_d.thr = new_thr;
                if (new_thr < st_q.thr) begin
                    if (busy && (new_thr <= st_q.pend_prio)) begin
                        st_d.pend_id = '0;
                        st_d.irq     = 1'b0;
                        st_d.rej_v   = 1'b1;
                        st_d.rej_id  = st_q.pend_id;
                    end
                end else if (!busy) begin
                    st_d.resend = 1'b1;
                    if (ipi_take) begin
                        st_d.pend_id   = IPI_CODE;
                        st_d.pend_prio = ipi_cand;
                        st_d.irq       = 1'b1;
                    end
                end
            end
            CMD_EOI: begin
                st_d.eoi_v  = 1'b1;
                st_d.eoi_id = cmd_word[ID_W-1:0];
                st_d.thr    = new_thr;
                if (!busy) begin
                    st_d.resend = 1'b1;
                    if (ipi_take) begin
                        st_d.pend_id   = IPI_CODE;
                        st_d.pend_prio = ipi_cand;
                        st_d.irq       = 1'b1;
                    end
                end
            end
            CMD_ACC: begin
                st_d.rd_v    = 1'b1;
                st_d.rd_data = {st_q.thr, st_q.pend_id};
                st_d.irq     = 1'b0;
                st_d.thr     = st_q.pend_prio;
                st_d.pend_id = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ipi       <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign rej_valid = st_q.rej_v;
    assign rej_id    = st_q.rej_id;
    assign resend    = st_q.resend;
    assign eoi_valid = st_q.eoi_v;
    assign eoi_id    = st_q.eoi_id;
    assign rd_valid  = st_q.rd_v;
    assign rd_data   = st_q.rd_data;

    // R4: the line is high exactly when the slot holds an id
    p_line_follows_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq == (st_q.pend_id != '0));

    // R2: accept empties the slot and drops the line
    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_ACC) |=> (rd_valid && !irq && st_q.pend_id == '0));

    // R3: a request at or above the threshold bounces and leaves the slot alone
    p_reject_keeps_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_REQ && cmd_prio >= st_q.thr)
        |=> (rej_valid && rej_id == $past(cmd_id) && $stable(st_q.pend_id)));

    // R9: end-of-interrupt forwards the id and restores the threshold
    p_eoi_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_EOI)
        |=> (eoi_valid && eoi_id == $past(cmd_word[ID_W-1:0])
             && st_q.thr == $past(cmd_word[STATUS_W-1 -: PRIO_W])));

    // R6: an inter-processor value at or above the threshold leaves the slot alone
    p_ipi_high_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_IPI && cmd_word[PRIO_W-1:0] >= st_q.thr)
        |=> ($stable(st_q.pend_id) && !rej_valid));
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
    import ipc_pkg::*;
#(
    parameter int ID_W   = 24,
    parameter int PRIO_W = 8,
    parameter int IPI_ID = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [1:0]               op_code,
    input  logic [PRIO_W+ID_W-1:0]   op_data,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ID_W-1:0]          req_id,
    input  logic [PRIO_W-1:0]        req_prio,
    output logic                     irq_out,
    output logic                     rej_valid,
    output logic [ID_W-1:0]          rej_id,
    output logic                     resend_req,
    output logic                     eoi_valid,
    output logic [ID_W-1:0]          eoi_id,
    output logic                     acc_valid,
    output logic [PRIO_W+ID_W-1:0]   acc_word
);
    localparam int STATUS_W = PRIO_W + ID_W;

    ipc_cmd_e              cmd_kind;
    logic [STATUS_W-1:0]   cmd_word;
    logic [ID_W-1:0]       cmd_id;
    logic [PRIO_W-1:0]     cmd_prio;

    ipc_arb #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_data   (op_data),
        .req_valid (req_valid),
        .req_id    (req_id),
        .req_prio  (req_prio),
        .req_ready (req_ready),
        .cmd_kind  (cmd_kind),
        .cmd_word  (cmd_word),
        .cmd_id    (cmd_id),
        .cmd_prio  (cmd_prio)
    );

    ipc_core #(.ID_W(ID_W), .PRIO_W(PRIO_W), .IPI_ID(IPI_ID)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_kind  (cmd_kind),
        .cmd_word  (cmd_word),
        .cmd_id    (cmd_id),
        .cmd_prio  (cmd_prio),
        .irq       (irq_out),
        .rej_valid (rej_valid),
        .rej_id    (rej_id),
        .resend    (resend_req),
        .eoi_valid (eoi_valid),
        .eoi_id    (eoi_id),
        .rd_valid  (acc_valid),
        .rd_data   (acc_word)
    );
endmodule

// File: tb/intr_present_ctrl_bench.sv
module intr_present_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] C_THR = 2'd0;
    localparam logic [1:0] C_IPI = 2'd1;
    localparam logic [1:0] C_ACC = 2'd2;
    localparam logic [1:0] C_EOI = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] op_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_id = '0;
    logic [7:0]  req_prio = '0;
    logic        irq_out, rej_valid, resend_req, eoi_valid, acc_valid;
    logic [23:0] rej_id, eoi_id;
    logic [31:0] acc_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        c_irq, c_rej, c_resend, c_eoi, c_acc;
    logic [23:0] c_rej_id, c_eoi_id;
    logic [31:0] c_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_present_ctrl u_intr_present_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_prio(req_prio), .irq_out(irq_out),
        .rej_valid(rej_valid), .rej_id(rej_id), .resend_req(resend_req),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .acc_valid(acc_valid),
        .acc_word(acc_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic grab();
        c_irq = irq_out;   c_rej = rej_valid;    c_rej_id = rej_id;
        c_resend = resend_req; c_eoi = eoi_valid; c_eoi_id = eoi_id;
        c_acc = acc_valid; c_word = acc_word;
    endtask

    task automatic do_op(input logic [1:0] code, input logic [31:0] data);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_data = data;
        @(negedge clk);
        op_valid = 1'b0;
        grab();
    endtask

    task automatic do_req(input logic [23:0] id, input logic [7:0] prio);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_prio = prio;
        @(negedge clk);
        req_valid = 1'b0;
        grab();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq_out), 32'd0);
        chk("R1 notices idle", {29'd0, rej_valid, resend_req, eoi_valid}, 32'd0);
        chk("R10 ready idle", 32'(req_ready), 32'd1);
        do_op(C_ACC, 32'd0);
        chk("R2 accept valid", 32'(c_acc), 32'd1);
        chk("R1 R2 reset status word", c_word, 32'h0000_0000);
        do_op(C_THR, 32'h10);
        chk("R8 resend on raise", 32'(c_resend), 32'd1);
        chk("R1 ipi 0xff gives no load", 32'(c_irq), 32'd0);
    endtask

    task automatic t_request_rules();
        do_req(24'h21, 8'h10);
        chk("R3 equal to thr rejected", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h21});
        chk("R3 slot untouched", 32'(c_irq), 32'd0);
        do_req(24'h20, 8'h30);
        chk("R3 above thr rejected", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h20});
        do_req(24'h22, 8'h08);
        chk("R4 winner raises line", {31'd0, c_irq}, 32'd1);
        chk("R4 no reject on empty slot", 32'(c_rej), 32'd0);
        do_req(24'h23, 8'h08);
        chk("R3 equal to pending rejected", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h23});
        do_req(24'h24, 8'h03);
        chk("R4 displaced id rejected", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h22});
        chk("R4 line stays high", 32'(c_irq), 32'd1);
    endtask

    task automatic t_accept_eoi();
        do_op(C_ACC, 32'd0);
        chk("R2 accept word", c_word, 32'h1000_0024);
        chk("R2 line low after accept", 32'(c_irq), 32'd0);
        do_op(C_EOI, 32'h1000_0024);
        chk("R9 eoi notice", {c_eoi, 7'd0, c_eoi_id}, {1'b1, 7'd0, 24'h24});
        chk("R9 resend when empty", 32'(c_resend), 32'd1);
        do_op(C_ACC, 32'd0);
        chk("R9 threshold restored", c_word, 32'h1000_0000);
        do_op(C_EOI, 32'h1000_0000);
        do_req(24'h25, 8'h04);
        do_op(C_EOI, 32'h0C00_0099);
        chk("R9 no resend while pending", 32'(c_resend), 32'd0);
        do_op(C_ACC, 32'd0);
        chk("R9 thr from eoi top byte", c_word, 32'h0C00_0025);
        do_op(C_EOI, 32'h1000_0025);
    endtask

    task automatic t_ipi_basic();
        do_op(C_IPI, 32'h05);
        chk("R5 ipi raises line", 32'(c_irq), 32'd1);
        chk("R5 no reject", 32'(c_rej), 32'd0);
        do_op(C_ACC, 32'd0);
        chk("R5 ipi id 2", c_word, 32'h1000_0002);
        do_op(C_EOI, 32'h1000_0002);
        chk("R9 eoi reloads ipi", {30'd0, c_resend, c_irq}, 32'd3);
        do_op(C_ACC, 32'd0);
        chk("R5 ipi again", c_word, 32'h1000_0002);
        do_op(C_IPI, 32'hFF);
        do_op(C_EOI, 32'h1000_0002);
        chk("R9 resend without ipi", {30'd0, c_resend, c_irq}, 32'd2);
        do_op(C_ACC, 32'd0);
        do_op(C_EOI, 32'h1000_0000);
    endtask

    task automatic t_ipi_suppress();
        do_req(24'h30, 8'h04);
        do_op(C_IPI, 32'h06);
        chk("R6 pending more favoured keeps slot", {30'd0, c_rej, c_irq}, 32'd1);
        do_op(C_IPI, 32'h02);
        chk("R5 ipi displaces pending", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h30});
        do_op(C_ACC, 32'd0);
        chk("R5 displaced slot holds ipi", c_word, 32'h1000_0002);
        do_op(C_IPI, 32'hFF);
        do_op(C_EOI, 32'h1000_0002);
        do_op(C_IPI, 32'h20);
        chk("R6 ipi above thr ignored", {30'd0, c_rej, c_irq}, 32'd0);
        do_op(C_ACC, 32'd0);
        chk("R6 slot still empty", c_word, 32'h1000_0000);
        do_op(C_EOI, 32'h1000_0000);
        do_op(C_IPI, 32'hFF);
    endtask

    task automatic t_thr_lower();
        do_req(24'h40, 8'h08);
        do_op(C_THR, 32'h08);
        chk("R7 lower thr rejects pending", {c_rej, 7'd0, c_rej_id}, {1'b1, 7'd0, 24'h40});
        chk("R7 line dropped", 32'(c_irq), 32'd0);
        do_op(C_ACC, 32'd0);
        chk("R7 slot cleared", c_word, 32'h0800_0000);
        do_op(C_THR, 32'h10);
        do_req(24'h41, 8'h02);
        do_op(C_THR, 32'h05);
        chk("R7 favoured pending kept", {29'd0, c_rej, c_resend, c_irq}, 32'd1);
        do_op(C_ACC, 32'd0);
        chk("R7 word after keep", c_word, 32'h0500_0041);
        do_op(C_EOI, 32'h1000_0041);
    endtask

    task automatic t_thr_raise_ipi();
        do_op(C_IPI, 32'h30);
        chk("R6 ipi at/above thr no line", 32'(c_irq), 32'd0);
        do_op(C_THR, 32'h40);
        chk("R8 raise loads ipi and resends", {30'd0, c_resend, c_irq}, 32'd3);
        do_op(C_ACC, 32'd0);
        chk("R8 ipi word", c_word, 32'h4000_0002);
    endtask

    task automatic t_precedence();
        @(negedge clk);
        op_valid = 1'b1; op_code = C_IPI; op_data = 32'hFF;
        req_valid = 1'b1; req_id = 24'h50; req_prio = 8'h01;
        #1;
        chk("R10 ready low during op", 32'(req_ready), 32'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10 request not yet taken", 32'(irq_out), 32'd0);
        #1;
        chk("R10 ready back", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 request taken later", 32'(irq_out), 32'd1);
        do_op(C_ACC, 32'd0);
        chk("R10 held request word", c_word, 32'h3000_0050);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_request_rules();
        t_accept_eoi();
        t_ipi_basic();
        t_ipi_suppress();
        t_thr_lower();
        t_thr_raise_ipi();
        t_precedence();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule